// File: doc/BRIEF.md
# Reference Signal Pre-Computation for a Reduced-State Equalizer

This block supplies the reference signals that a reduced-state trellis equalizer compares against each received sample. Each reference is the sum of two parts. The state part is the survivor symbols of a predecessor state weighted by channel taps 1 to L-1. The branch part is the candidate new symbol weighted by tap 0. The block keeps both parts in a flip-flop store, so each part is computed once and reused for every branch that needs it.

Two passes run through one complex multiplier, one product per cycle. A branch pass is started once per trellis stage. It captures the channel taps and fills one branch word for each of the M alphabet symbols. A state pass is started once per group of J1 predecessor states. It captures their survivor indices and fills J1 state words, replacing the previous group. Symbol indices are turned into complex constellation points by an internal table, which is loaded through a write port.

A read port has NRD lanes that all run in the same cycle. Each lane pairs one state word with one branch word and returns their sum one cycle later, saturated to the output width. The metric computation that consumes these references sits outside the block.

Top module: `refgen_precomp`

## Requirements
- R1: After reset, `busy` and `refValid` are low, and every lane reads 0 for any state/symbol pair, because both stores clear to zero.
- R2: A `brStart` pulse while idle captures `tapsI`/`tapsQ` (tap k in bits [k*W +: W]). `busy` is then high for exactly M cycles, and branch word m becomes lut[m]·tap0 as a complex product (re = aI·bI − aQ·bQ, im = aI·bQ + aQ·bI).
- R3: An `stStart` pulse while idle captures `survIdx`, where the symbol of state j at delay d (1..L−1) sits in bits [(j*(L−1)+d−1)*SYMW +: SYMW]. `busy` is then high for exactly J1·(L−1) cycles, and state word j becomes the sum over d of lut[symbol(j,d)]·tap_d.
- R4: A cycle with `rdEn` high makes `refValid` high in the next cycle. In that cycle, lane i (rdState in bits [i*STW +: STW], rdSym in bits [i*SYMW +: SYMW], result in bits [i*OW +: OW]) carries stateWord[rdState] + branchWord[rdSym], and all lanes are independent.
- R5: Each reference component is saturated to a signed OW-bit value: sums above 2^(OW−1)−1 clamp to that value, and sums below −2^(OW−1) clamp to −2^(OW−1).
- R6: `refValid` is low in the cycle after a cycle with `rdEn` low.
- R7: A start pulse that arrives while `busy` is high is ignored. When `brStart` and `stStart` arrive together while idle, only the branch pass runs, and the state words keep their old values.
- R8: The state pass uses the taps captured by the last branch pass. Changes on `tapsI`/`tapsQ` after that capture do not affect it.
- R9: Branch words stay valid across state passes, and state words stay valid across branch passes, until their own pass rewrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lutWe | input | 1 | Write enable for the constellation table |
| lutAddr | input | SYMW | Symbol index being written |
| lutI | input | W | In-phase value of the constellation point |
| lutQ | input | W | Quadrature value of the constellation point |
| tapsI | input | L*W | In-phase channel taps, tap k at [k*W +: W] |
| tapsQ | input | L*W | Quadrature channel taps |
| brStart | input | 1 | Start a branch pass (new trellis stage) |
| stStart | input | 1 | Start a state pass (new predecessor group) |
| survIdx | input | J1*(L-1)*SYMW | Survivor symbol indices of the group |
| busy | output | 1 | A pass is in progress |
| rdEn | input | 1 | Read request for all lanes |
| rdState | input | NRD*STW | State word index per lane |
| rdSym | input | NRD*SYMW | Branch word (symbol) index per lane |
| refValid | output | 1 | Lane results are valid |
| refI | output | NRD*OW | In-phase reference per lane, saturated |
| refQ | output | NRD*OW | Quadrature reference per lane, saturated |

## Verification
Pass lengths are measured from the clock edge that samples the start pulse. From that edge, `busy` must read high on exactly M falling edges for a branch pass, or J1·(L−1) falling edges for a state pass, before it drops. The bench reads stored words only after `busy` has fallen. Read results are due one edge after the edge that samples `rdEn`. The bench raises `rdEn` at a falling edge, drops it at the next falling edge, and compares every lane there against sums and clamps computed from its own model of the table, the captured taps and the survivors.

// File: rtl/refgen_pkg.sv
package refgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BRANCH = 2'd1,
    PH_STATE  = 2'd2
  } phase_t;

  typedef struct packed {
    logic tapLd;   // capture taps into the datapath
    logic survLd;  // capture survivor indices
    logic brWr;    // write the current product to a branch word
    logic stMode;  // multiplier serves the state pass
    logic accClr;  // first tap of a state: restart the accumulation
    logic stWr;    // last tap of a state: write the state word
  } ctlStrobe_t;

endpackage

// File: rtl/refgen_ctrl.sv
module refgen_ctrl
  import refgen_pkg::*;
#(
  parameter int M  = 16,
  parameter int J1 = 4,
  parameter int L  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    brStart,
  input  logic                    stStart,
  output ctlStrobe_t              strb,
  output logic [$clog2(M)-1:0]    symSel,
  output logic [$clog2(J1)-1:0]   stSel,
  output logic [$clog2(L)-1:0]    tapSel,
  output logic                    busy
);
  localparam int SYMW = $clog2(M);
  localparam int STW  = $clog2(J1);
  localparam int TAPW = $clog2(L);
  localparam logic [SYMW-1:0] BR_LAST  = SYMW'(M - 1);
  localparam logic [STW-1:0]  ST_LAST  = STW'(J1 - 1);
  localparam logic [TAPW-1:0] TAP_LAST = TAPW'(L - 1);
  localparam logic [TAPW-1:0] TAP_FIRST = TAPW'(1);

  phase_t          phase;
  logic [SYMW-1:0] brCnt;
  logic [STW-1:0]  stCnt;
  logic [TAPW-1:0] tapCnt;
  logic            idle;

  assign idle = (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      brCnt  <= '0;
      stCnt  <= '0;
      tapCnt <= TAP_FIRST;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (brStart) begin
            phase <= PH_BRANCH;
            brCnt <= '0;
          end else if (stStart) begin
            phase  <= PH_STATE;
            stCnt  <= '0;
            tapCnt <= TAP_FIRST;
          end
        end
        PH_BRANCH: begin
          brCnt <= brCnt + 1'b1;
          if (brCnt == BR_LAST) phase <= PH_IDLE;
        end
        PH_STATE: begin
          if (tapCnt == TAP_LAST) begin
            tapCnt <= TAP_FIRST;
            stCnt  <= stCnt + 1'b1;
            if (stCnt == ST_LAST) phase <= PH_IDLE;
          end else begin
            tapCnt <= tapCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.tapLd  = idle && brStart;
    strb.survLd = idle && !brStart && stStart;
    strb.brWr   = (phase == PH_BRANCH);
    strb.stMode = (phase == PH_STATE);
    strb.accClr = (phase == PH_STATE) && (tapCnt == TAP_FIRST);
    strb.stWr   = (phase == PH_STATE) && (tapCnt == TAP_LAST);
  end

  assign symSel = brCnt;
  assign stSel  = stCnt;
  assign tapSel = tapCnt;
  assign busy   = !idle;

  // R7
  start_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(brStart || stStart));

  // R2
  branch_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_BRANCH && brCnt != BR_LAST) |=> (phase == PH_BRANCH));

  // R3
  state_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STATE && !(stCnt == ST_LAST && tapCnt == TAP_LAST)) |=> (phase == PH_STATE));

endmodule

// File: rtl/refgen_dp.sv
module refgen_dp
  import refgen_pkg::*;
#(
  parameter int M   = 16,
  parameter int J1  = 4,
  parameter int L   = 4,
  parameter int W   = 10,
  parameter int OW  = 20,
  parameter int NRD = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrobe_t                    strb,
  input  logic [$clog2(M)-1:0]          symSel,
  input  logic [$clog2(J1)-1:0]         stSel,
  input  logic [$clog2(L)-1:0]          tapSel,
  input  logic                          lutWe,
  input  logic [$clog2(M)-1:0]          lutAddr,
  input  logic signed [W-1:0]           lutI,
  input  logic signed [W-1:0]           lutQ,
  input  logic [L*W-1:0]                tapsI,
  input  logic [L*W-1:0]                tapsQ,
  input  logic [J1*(L-1)*$clog2(M)-1:0] survIdx,
  input  logic                          rdEn,
  input  logic [NRD*$clog2(J1)-1:0]     rdState,
  input  logic [NRD*$clog2(M)-1:0]      rdSym,
  output logic                          refValid,
  output logic [NRD*OW-1:0]             refI,
  output logic [NRD*OW-1:0]             refQ
);
  localparam int SYMW = $clog2(M);
  localparam int STW  = $clog2(J1);
  localparam int NSV  = J1 * (L - 1);
  localparam int SVW  = $clog2(NSV);
  localparam int PW   = 2 * W + 1;
  localparam int AW   = PW + $clog2(L);
  localparam int SW   = AW + 1;
  localparam logic signed [SW-1:0] SAT_HI = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [SW-1:0] SAT_LO = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [W-1:0]  lutRegI [M];
  logic signed [W-1:0]  lutRegQ [M];
  logic signed [W-1:0]  tapRegI [L];
  logic signed [W-1:0]  tapRegQ [L];
  logic [SYMW-1:0]      survReg [NSV];
  logic signed [AW-1:0] brMemI  [M];
  logic signed [AW-1:0] brMemQ  [M];
  logic signed [AW-1:0] stMemI  [J1];
  logic signed [AW-1:0] stMemQ  [J1];
  logic signed [AW-1:0] accI, accQ;

  // operand selection for the shared complex multiplier
  logic [SVW-1:0]       survPos;
  logic [SYMW-1:0]      opSym;
  logic [$clog2(L)-1:0] opTap;
  logic signed [PW-1:0] aIx, aQx, bIx, bQx, prodI, prodQ;
  logic signed [AW-1:0] prodIx, prodQx, accNextI, accNextQ;

  always_comb begin
    survPos = SVW'(stSel) * SVW'(L - 1) + SVW'(tapSel) - SVW'(1);
    opSym   = strb.stMode ? survReg[survPos] : symSel;
    opTap   = strb.stMode ? tapSel : '0;
    aIx     = {{(PW-W){lutRegI[opSym][W-1]}}, lutRegI[opSym]};
    aQx     = {{(PW-W){lutRegQ[opSym][W-1]}}, lutRegQ[opSym]};
    bIx     = {{(PW-W){tapRegI[opTap][W-1]}}, tapRegI[opTap]};
    bQx     = {{(PW-W){tapRegQ[opTap][W-1]}}, tapRegQ[opTap]};
    prodI   = aIx * bIx - aQx * bQx;
    prodQ   = aIx * bQx + aQx * bIx;
    prodIx  = {{(AW-PW){prodI[PW-1]}}, prodI};
    prodQx  = {{(AW-PW){prodQ[PW-1]}}, prodQ};
    accNextI = (strb.accClr ? '0 : accI) + prodIx;
    accNextQ = (strb.accClr ? '0 : accQ) + prodQx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int m = 0; m < M; m++) begin
        lutRegI[m] <= '0; lutRegQ[m] <= '0;
        brMemI[m]  <= '0; brMemQ[m]  <= '0;
      end
      for (int k = 0; k < L; k++) begin
        tapRegI[k] <= '0; tapRegQ[k] <= '0;
      end
      for (int s = 0; s < NSV; s++) survReg[s] <= '0;
      for (int j = 0; j < J1; j++) begin
        stMemI[j] <= '0; stMemQ[j] <= '0;
      end
      accI <= '0;
      accQ <= '0;
    end else begin
      if (lutWe) begin
        lutRegI[lutAddr] <= lutI;
        lutRegQ[lutAddr] <= lutQ;
      end
      if (strb.tapLd) begin
        for (int k = 0; k < L; k++) begin
          tapRegI[k] <= tapsI[k*W +: W];
          tapRegQ[k] <= tapsQ[k*W +: W];
        end
      end
      if (strb.survLd) begin
        for (int s = 0; s < NSV; s++) survReg[s] <= survIdx[s*SYMW +: SYMW];
      end
      if (strb.brWr) begin
        brMemI[symSel] <= prodIx;
        brMemQ[symSel] <= prodQx;
      end
      if (strb.stMode) begin
        accI <= accNextI;
        accQ <= accNextQ;
      end
      if (strb.stWr) begin
        stMemI[stSel] <= accNextI;
        stMemQ[stSel] <= accNextQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refValid <= 1'b0;
    else       refValid <= rdEn;
  end

  for (genvar g = 0; g < NRD; g++) begin : gLane
    logic [STW-1:0]       rs;
    logic [SYMW-1:0]      rb;
    logic signed [SW-1:0] sumI, sumQ;
    logic [OW-1:0]        satI, satQ;

    assign rs   = rdState[g*STW +: STW];
    assign rb   = rdSym[g*SYMW +: SYMW];
    assign sumI = {stMemI[rs][AW-1], stMemI[rs]} + {brMemI[rb][AW-1], brMemI[rb]};
    assign sumQ = {stMemQ[rs][AW-1], stMemQ[rs]} + {brMemQ[rb][AW-1], brMemQ[rb]};

    always_comb begin
      if (sumI > SAT_HI)      satI = {1'b0, {(OW-1){1'b1}}};
      else if (sumI < SAT_LO) satI = {1'b1, {(OW-1){1'b0}}};
      else                    satI = sumI[OW-1:0];
      if (sumQ > SAT_HI)      satQ = {1'b0, {(OW-1){1'b1}}};
      else if (sumQ < SAT_LO) satQ = {1'b1, {(OW-1){1'b0}}};
      else                    satQ = sumQ[OW-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        refI[g*OW +: OW] <= '0;
        refQ[g*OW +: OW] <= '0;
      end else if (rdEn) begin
        refI[g*OW +: OW] <= satI;
        refQ[g*OW +: OW] <= satQ;
      end
    end
  end

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.brWr, strb.stMode, strb.tapLd || strb.survLd}));

  // R3
  stwr_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stWr |-> strb.stMode);

  // R8
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stMode |=> ($stable(tapRegI[0]) && $stable(tapRegQ[0])));

endmodule

// File: rtl/refgen_precomp.sv
module refgen_precomp
  import refgen_pkg::*;
#(
  parameter int M   = 16,
  parameter int J1  = 4,
  parameter int L   = 4,
  parameter int W   = 10,
  parameter int OW  = 20,
  parameter int NRD = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lutWe,
  input  logic [$clog2(M)-1:0]          lutAddr,
  input  logic signed [W-1:0]           lutI,
  input  logic signed [W-1:0]           lutQ,
  input  logic [L*W-1:0]                tapsI,
  input  logic [L*W-1:0]                tapsQ,
  input  logic                          brStart,
  input  logic                          stStart,
  input  logic [J1*(L-1)*$clog2(M)-1:0] survIdx,
  output logic                          busy,
  input  logic                          rdEn,
  input  logic [NRD*$clog2(J1)-1:0]     rdState,
  input  logic [NRD*$clog2(M)-1:0]      rdSym,
  output logic                          refValid,
  output logic [NRD*OW-1:0]             refI,
  output logic [NRD*OW-1:0]             refQ
);
  ctlStrobe_t            strb;
  logic [$clog2(M)-1:0]  symSel;
  logic [$clog2(J1)-1:0] stSel;
  logic [$clog2(L)-1:0]  tapSel;

  refgen_ctrl #(.M(M), .J1(J1), .L(L)) uCtrl (
    .clk(clk), .rstN(rstN), .brStart(brStart), .stStart(stStart),
    .strb(strb), .symSel(symSel), .stSel(stSel), .tapSel(tapSel), .busy(busy)
  );

  refgen_dp #(.M(M), .J1(J1), .L(L), .W(W), .OW(OW), .NRD(NRD)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .symSel(symSel), .stSel(stSel),
    .tapSel(tapSel), .lutWe(lutWe), .lutAddr(lutAddr), .lutI(lutI), .lutQ(lutQ),
    .tapsI(tapsI), .tapsQ(tapsQ), .survIdx(survIdx), .rdEn(rdEn),
    .rdState(rdState), .rdSym(rdSym), .refValid(refValid), .refI(refI), .refQ(refQ)
  );

endmodule

// File: tb/refgen_precomp_test.sv
module refgen_precomp_test;
  localparam int M = 16, J1 = 4, L = 4, W = 10, OW = 20, NRD = 4;
  localparam int SYMW = $clog2(M), STW = $clog2(J1);

  logic clk = 1'b0, rstN = 1'b0;
  logic lutWe = 1'b0;
  logic [SYMW-1:0] lutAddr = '0;
  logic signed [W-1:0] lutI = '0, lutQ = '0;
  logic [L*W-1:0] tapsI = '0, tapsQ = '0;
  logic brStart = 1'b0, stStart = 1'b0;
  logic [J1*(L-1)*SYMW-1:0] survIdx = '0;
  logic busy, rdEn = 1'b0, refValid;
  logic [NRD*STW-1:0] rdState = '0;
  logic [NRD*SYMW-1:0] rdSym = '0;
  logic [NRD*OW-1:0] refI, refQ;

  refgen_precomp #(.M(M), .J1(J1), .L(L), .W(W), .OW(OW), .NRD(NRD)) uut (
    .clk(clk), .rstN(rstN), .lutWe(lutWe), .lutAddr(lutAddr), .lutI(lutI), .lutQ(lutQ),
    .tapsI(tapsI), .tapsQ(tapsQ), .brStart(brStart), .stStart(stStart), .survIdx(survIdx),
    .busy(busy), .rdEn(rdEn), .rdState(rdState), .rdSym(rdSym), .refValid(refValid),
    .refI(refI), .refQ(refQ)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nFail = 0, cycles = 0;
  longint mLutI[M], mLutQ[M], tapI[L], tapQ[L], capI[L], capQ[L];
  longint expBrI[M], expBrQ[M], expStI[J1], expStQ[J1];
  int surv[J1][L];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    longint hi = (64'sd1 <<< (OW - 1)) - 1;
    longint lo = -(64'sd1 <<< (OW - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint rnd10();
    return longint'($urandom_range(0, 1023)) - 512;
  endfunction

  task automatic wrLut(input int m, input longint i, input longint q);
    @(negedge clk);
    lutWe = 1'b1; lutAddr = SYMW'(m); lutI = W'(i); lutQ = W'(q);
    mLutI[m] = i; mLutQ[m] = q;
    @(negedge clk);
    lutWe = 1'b0;
  endtask

  task automatic driveTaps();
    for (int k = 0; k < L; k++) begin
      tapsI[k*W +: W] = W'(tapI[k]);
      tapsQ[k*W +: W] = W'(tapQ[k]);
    end
  endtask

  // mode 0: plain, 1: stStart in same cycle, 2: stStart pulsed mid-pass
  task automatic doBranch(input int mode, input string req);
    int n = 0;
    driveTaps();
    for (int k = 0; k < L; k++) begin capI[k] = tapI[k]; capQ[k] = tapQ[k]; end
    for (int m = 0; m < M; m++) begin
      expBrI[m] = mLutI[m] * capI[0] - mLutQ[m] * capQ[0];
      expBrQ[m] = mLutI[m] * capQ[0] + mLutQ[m] * capI[0];
    end
    @(negedge clk);
    brStart = 1'b1; stStart = (mode == 1);
    @(negedge clk);
    brStart = 1'b0; stStart = 1'b0;
    while (busy) begin
      n++;
      stStart = (mode == 2 && n == 3);
      @(negedge clk);
    end
    stStart = 1'b0;
    chk({req, " branch busy length"}, n, M);
  endtask

  task automatic doState(input string req);
    int n = 0;
    for (int j = 0; j < J1; j++) begin
      expStI[j] = 0; expStQ[j] = 0;
      for (int d = 1; d < L; d++) begin
        int s = surv[j][d];
        survIdx[(j*(L-1)+d-1)*SYMW +: SYMW] = SYMW'(s);
        expStI[j] += mLutI[s] * capI[d] - mLutQ[s] * capQ[d];
        expStQ[j] += mLutI[s] * capQ[d] + mLutQ[s] * capI[d];
      end
    end
    @(negedge clk);
    stStart = 1'b1;
    @(negedge clk);
    stStart = 1'b0;
    while (busy) begin n++; @(negedge clk); end
    chk({req, " state busy length"}, n, J1 * (L - 1));
  endtask

  task automatic readLanes(input int st[NRD], input int sy[NRD], input string req);
    for (int i = 0; i < NRD; i++) begin
      rdState[i*STW +: STW] = STW'(st[i]);
      rdSym[i*SYMW +: SYMW] = SYMW'(sy[i]);
    end
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    chk({req, " refValid"}, longint'(refValid), 1);
    for (int i = 0; i < NRD; i++) begin
      chk({req, " refI"}, longint'($signed(refI[i*OW +: OW])), sat(expStI[st[i]] + expBrI[sy[i]]));
      chk({req, " refQ"}, longint'($signed(refQ[i*OW +: OW])), sat(expStQ[st[i]] + expBrQ[sy[i]]));
    end
    @(negedge clk);
    chk("R6 refValid drops", longint'(refValid), 0);
  endtask

  task automatic randRead(input string req);
    int st[NRD], sy[NRD];
    for (int i = 0; i < NRD; i++) begin
      st[i] = $urandom_range(0, J1 - 1);
      sy[i] = $urandom_range(0, M - 1);
    end
    readLanes(st, sy, req);
  endtask

  task automatic randSurv();
    for (int j = 0; j < J1; j++)
      for (int d = 1; d < L; d++) surv[j][d] = $urandom_range(0, M - 1);
  endtask

  initial begin
    int seedDummy, st[NRD], sy[NRD];
    seedDummy = $urandom(32'h00c0ffee);
    for (int m = 0; m < M; m++) begin mLutI[m] = 0; mLutQ[m] = 0; expBrI[m] = 0; expBrQ[m] = 0; end
    for (int j = 0; j < J1; j++) begin expStI[j] = 0; expStQ[j] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy after reset", longint'(busy), 0);
    chk("R1 refValid after reset", longint'(refValid), 0);
    randRead("R1 cleared stores");

    // R2, R3, R4: random rounds
    for (int r = 0; r < 6; r++) begin
      for (int m = 0; m < M; m++) wrLut(m, rnd10(), rnd10());
      for (int k = 0; k < L; k++) begin tapI[k] = rnd10(); tapQ[k] = rnd10(); end
      doBranch(0, "R2");
      randRead("R2 branch plus old state");
      // R8: taps change after capture
      for (int k = 0; k < L; k++) begin tapI[k] = rnd10(); tapQ[k] = rnd10(); end
      driveTaps();
      randSurv();
      doState("R3");
      for (int t = 0; t < 4; t++) randRead("R4 R8 random lanes");
    end

    // R9: a new state pass leaves branch words intact
    randSurv();
    doState("R9");
    randRead("R9 branch words kept");

    // R7: stStart during branch pass and together with brStart is ignored
    for (int k = 0; k < L; k++) begin tapI[k] = rnd10(); tapQ[k] = rnd10(); end
    doBranch(2, "R7 mid-pass start");
    randRead("R7 state words unchanged mid-pass");
    doBranch(1, "R7 simultaneous start");
    randRead("R7 state words unchanged simultaneous");

    // R5: saturation both ways
    wrLut(0, -512, 0);
    wrLut(1, 511, 0);
    for (int k = 0; k < L; k++) begin tapI[k] = -512; tapQ[k] = 0; end
    doBranch(0, "R5");
    for (int j = 0; j < J1; j++)
      for (int d = 1; d < L; d++) surv[j][d] = j % 2;
    doState("R5");
    for (int i = 0; i < NRD; i++) begin st[i] = i; sy[i] = i % 2; end
    readLanes(st, sy, "R5 clamp");
    chk("R5 positive clamp", longint'($signed(refI[0 +: OW])), (64'sd1 <<< (OW - 1)) - 1);
    chk("R5 negative clamp", longint'($signed(refI[OW +: OW])), -(64'sd1 <<< (OW - 1)));

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule